// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits between the storage array and the read data bus of a self-timed non-volatile memory. While an internal program cycle runs, the array contents cannot be returned, so each read instead returns two status bits. The top bit is the inverse of the top bit of the last byte the host loaded. The bit just below it flips on every read. A host can therefore poll until the top bit matches the value it wrote, or until two consecutive reads return the same second bit. Once the program cycle ends, reads return true array data again.

The block sees a busy flag from the program timer, a one-cycle load strobe with the top bit of each loaded byte, a one-cycle read strobe, and the array word. It drives one registered read word. That word is updated only on a read strobe and holds its value between reads.

Top module: `wr_status_rpt`

## Requirements
- R1: After a synchronous active-low reset, the read data output is all zeros.
- R2: A read strobe sampled while busy is low makes the read data equal the array word present at that strobe, visible from the cycle after the strobe.
- R3: A read strobe sampled while busy is high makes bit 7 of the read data the complement of bit 7 of the last accepted loaded byte.
- R4: While busy, bit 6 of the read data alternates between successive reads. A toggle flip-flop, cleared by reset, flips on every read strobe, busy or not. Each busy read shows its value from before that strobe.
- R5: While busy, bits 5 to 0 of the read data carry a fixed fill pattern, zero by default.
- R6: A load strobe sampled while busy is low is accepted. After a series of loads, the polling bit reflects only the final byte loaded.
- R7: A load strobe sampled while busy is high is ignored, and the polling bit still reports the byte loaded before busy rose.
- R8: The read data holds its value in every cycle without a read strobe, even if busy or the array word change.
- R9: The first read after busy falls returns true array data. Further reads do not toggle bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | High while the self-timed program cycle runs |
| load_stb | input | 1 | One-cycle pulse per byte loaded by the host |
| load_msb | input | 1 | Bit 7 of the byte being loaded |
| rd_stb | input | 1 | One-cycle pulse per host read |
| arr_data | input | 8 | True word from the storage array |
| rd_data | output | 8 | Registered read data returned to the host |

## Verification
The hardest case to reach is a read whose toggle value depends on reads made long before the busy period. The toggle advances on every strobe, so the bench keeps its own running count of all reads since reset, and predicts bit 6 from that count's parity. A second hard case is a load arriving while busy. The bench issues one between two status reads and then checks that the polling bit still shows the earlier byte.

// File: rtl/wr_status_pkg.sv
// Shared constants for the write completion status reporter.
package wr_status_pkg;
    localparam int unsigned WSR_DATA_W = 8;   // default read word width
    localparam int unsigned WSR_MIN_W  = 3;   // poll bit, toggle bit, at least one fill bit
endpackage

// File: rtl/wsr_last_bit.sv
// Holds the polling-relevant bit of the last accepted byte load.
// Assumes load_stb is a single-cycle pulse; loads while busy are refused.
module wsr_last_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic load_stb,
    input  logic load_msb,
    output logic last_msb
);
    // Capture the top bit of each load accepted outside a program cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_msb <= 1'b0;
        else if (load_stb && !busy)
            last_msb <= load_msb;
    end

    // R7
    busy_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(last_msb));
    // R6
    load_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !busy) |=> (last_msb == $past(load_msb)));
endmodule

// File: rtl/wsr_toggle.sv
// Toggle flip-flop advanced once per read strobe, held between reads.
// Assumes rd_stb is a single-cycle pulse per host read.
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_stb,
    output logic tog
);
    // Flip on every read strobe, keep state otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tog <= 1'b0;
        else if (rd_stb)
            tog <= ~tog;
    end

    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(tog));
endmodule

// File: rtl/wsr_read_mux.sv
// Selects between status and array data and registers the read word.
// Assumes busy, last_msb and tog are synchronous to clk.
module wsr_read_mux #(
    parameter int unsigned        DATA_W = 8,
    parameter logic [DATA_W-3:0]  FILL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              rd_stb,
    input  logic              last_msb,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] status_word;

    // Build the word returned while a program cycle runs.
    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = ~last_msb;
        status_word[TOG_BIT]  = tog;
        status_word[TOG_BIT-1:0] = FILL;
    end

    // Load the read register only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_stb)
            rd_data <= busy ? status_word : arr_data;
    end

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));
    // R2
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> (rd_data == $past(arr_data)));
    // R3
    poll_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[POLL_BIT] == ~$past(last_msb)));
    // R5
    fill_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[TOG_BIT-1:0] == FILL));
    // R4
    tog_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data[TOG_BIT] == $past(tog)));
endmodule

// File: rtl/wr_status_rpt.sv
// Write completion status reporter: returns polling and toggle status
// in place of array data while a self-timed program cycle is busy.
// Assumes single-cycle strobes and a busy flag synchronous to clk.
module wr_status_rpt
    import wr_status_pkg::*;
#(
    parameter int unsigned       DATA_W = WSR_DATA_W,
    parameter logic [DATA_W-3:0] FILL   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              load_stb,
    input  logic              load_msb,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic last_msb;
    logic tog;

    // Width guard evaluated once at start.
    initial begin
        width_ok_chk: assert (DATA_W >= WSR_MIN_W);
    end

    wsr_last_bit u_last (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .load_stb (load_stb),
        .load_msb (load_msb),
        .last_msb (last_msb)
    );

    wsr_toggle u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .tog    (tog)
    );

    wsr_read_mux #(.DATA_W(DATA_W), .FILL(FILL)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .rd_stb   (rd_stb),
        .last_msb (last_msb),
        .tog      (tog),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/wr_status_rpt_test.sv
module wr_status_rpt_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0;
    logic       load_stb = 1'b0;
    logic       load_msb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    int reads_done = 0;     // model of toggle: strobes since reset
    logic model_msb = 1'b0; // model of last accepted load bit 7
    logic stb_seen = 1'b0;
    logic done = 1'b0;

    logic [7:0] q_exp[$];
    logic [7:0] q_mask[$];
    string      q_tag[$];

    always #5 clk = ~clk;

    wr_status_rpt uut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .load_stb(load_stb),
        .load_msb(load_msb), .rd_stb(rd_stb), .arr_data(arr_data),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act,
                         input logic [7:0] exp, input logic [7:0] mask);
        tests++;
        if ((act & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, mask);
        end
    endtask

    // Driver: one load strobe, updating the bench model when accepted.
    task automatic do_load(input logic [7:0] b);
        load_stb = 1'b1;
        load_msb = b[7];
        if (!busy) model_msb = b[7];
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    // Driver: one read strobe, pushing the predicted word into the scoreboard.
    task automatic do_read(input string tag);
        logic [7:0] e;
        logic [7:0] m;
        if (busy) begin
            e = {~model_msb, reads_done[0], 6'b0};
            m = 8'hFF;
        end else begin
            e = arr_data;
            m = 8'hFF;
        end
        q_exp.push_back(e);
        q_mask.push_back(m);
        q_tag.push_back(tag);
        reads_done++;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    always @(posedge clk) stb_seen <= rd_stb;

    // Monitor: compare each registered read word against the queue.
    always @(negedge clk) begin
        if (stb_seen && q_exp.size() > 0)
            check(q_tag.pop_front(), rd_data, q_exp.pop_front(), q_mask.pop_front());
    end

    initial begin
        logic [7:0] held;
        logic [7:0] b1;
        logic [7:0] b2;
        repeat (3) @(negedge clk);
        check("R1 reset", rd_data, 8'h00, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);

        arr_data = 8'h3C; do_read("R2 idle pass 3C");
        arr_data = 8'hA5; do_read("R2 idle pass A5");
        arr_data = 8'h7E; do_read("R2 idle pass 7E");

        do_load(8'h12); do_load(8'h34); do_load(8'h9F);  // page, last msb=1
        busy = 1'b1; @(negedge clk);
        arr_data = 8'h55;
        do_read("R3 R6 poll after page");
        do_read("R4 toggle read 2");
        do_read("R4 toggle read 3");
        b1 = rd_data;
        do_read("R4 toggle read 4");
        @(negedge clk);
        b2 = rd_data;
        check("R4 bit6 differs between reads", {1'b0, b2[6], 6'b0}, {1'b0, ~b1[6], 6'b0}, 8'h40);
        check("R5 fill bits", rd_data, 8'h00, 8'h3F);

        do_load(8'h01);                       // ignored while busy
        do_read("R7 load while busy ignored");

        held = rd_data;
        arr_data = 8'hC3;
        busy = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 hold without strobe", rd_data, held, 8'hFF);
        busy = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 hold across busy change", rd_data, held, 8'hFF);

        busy = 1'b0; @(negedge clk);
        do_read("R9 first read after busy");
        do_read("R9 second read true data");
        b1 = rd_data; @(negedge clk);
        do_read("R9 third read true data");
        @(negedge clk);
        check("R9 bit6 steady", rd_data, b1, 8'h40);

        do_load(8'h05);                       // msb=0
        busy = 1'b1; @(negedge clk);
        do_read("R3 poll bit for msb 0");
        do_read("R4 toggle after long history");
        busy = 1'b0; @(negedge clk);
        arr_data = 8'h80;
        do_read("R2 R9 return after second cycle");
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule